// File: doc/BRIEF.md
# Flash Bank Read Controller with Stall-and-Retry

This block links an AHB-Lite slave port to a single flash array bank. It accepts read transfers from the bus and turns each one into a bank read access that lasts a fixed number of clock cycles, `READ_CYCLES`. The bank data goes onto `hrdata` in the last cycle of the access, and `hreadyOut` is high in that same cycle. A following transfer can be accepted in that cycle, so sequential bursts run back to back.

The bank signals that it is busy with a high-voltage program or erase operation by pulling `bankDone` low. If that happens while an access is in progress, the controller drops the access and turns off the bank read enable. It then waits for `bankDone` to return high, leaves one idle cycle, and repeats the full access to the same address. For the whole episode the bus stays stalled with `hreadyOut` low and `hresp` OKAY. The master holds the pending data-phase read and the next address-phase transfer, and nothing is lost. The stall-and-retry mode is selected by a 3-bit mode field. Code 110 also raises a sticky stall-notification interrupt. Code 111 retries silently.

Top module: `flash_retry_reader`

## Requirements
- R1: An accepted read is one with `hsel` high, `htrans` equal to 2'b10 (NONSEQ) or 2'b11 (SEQ), `hwrite` low and `hready` high. When no stall occurs, `hreadyOut` goes high in the `READ_CYCLES`-th cycle after the accepting edge, with `hrdata` equal to the bank data for that address. `bankRdEn` is high and `bankAddr` equals the transfer address in that cycle.
- R2: If `bankDone` is low in any access cycle, that access is abandoned. `hreadyOut` is low in that cycle, and `bankRdEn` is low from the next cycle until the retry begins.
- R3: Once `bankDone` is seen high during the stall, the controller leaves one idle cycle and then repeats a full `READ_CYCLES`-cycle access to the same address. Suppose `bankDone` goes low in data-phase cycle k and stays low for L cycles. Then the data phase completes in cycle k+L+1+`READ_CYCLES`.
- R4: `hreadyOut` stays low throughout a stall and retry, so the address-phase transfer waiting behind the stalled read is not accepted until the retried read completes.
- R5: `hresp` is always 0 (OKAY), including during and after a stalled and retried read.
- R6: A stall raises `stallIrq` from the next cycle only when `rwwMode` is 3'b110. With 3'b111 the stall is retried and `stallIrq` stays low.
- R7: `stallIrq` is sticky. It stays high until `stallIrqClr` is pulsed, and it reads low in the cycle after the clear when no new stall occurs in the same cycle.
- R8: In a SEQ burst, the beat after a retried beat is accepted in the cycle the retried beat completes, and it reads the next word address (previous address + 4).
- R9: After reset, `hreadyOut` is 1, `bankRdEn` is 0 and `stallIrq` is 0.
- R10: Write transfers and IDLE transfers start no bank read. `bankRdEn` stays low and `hreadyOut` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select |
| htrans | input | 2 | AHB transfer type |
| haddr | input | ADDR_W | AHB address |
| hwrite | input | 1 | AHB write flag (writes are not served) |
| hready | input | 1 | Bus ready input (previous transfer finished) |
| hreadyOut | output | 1 | Slave ready; low while a read is in progress or stalled |
| hrdata | output | DATA_W | Read data, valid while hreadyOut is high at the end of a read |
| hresp | output | 1 | Transfer response, always OKAY |
| rwwMode | input | 3 | Read-while-write mode field; 110 retries with interrupt, 111 retries silently |
| stallIrqClr | input | 1 | Clears the sticky stall interrupt |
| stallIrq | output | 1 | Sticky stall-notification interrupt |
| bankAddr | output | ADDR_W | Address presented to the flash bank |
| bankRdEn | output | 1 | Bank read enable |
| bankRdata | input | DATA_W | Data from the flash bank |
| bankDone | input | 1 | Bank ready; low while a program or erase is running |

## Verification
The bench builds the block with `READ_CYCLES` = 3, `ADDR_W` = 16 and `DATA_W` = 32. With three access cycles, the bench can drop `bankDone` in the first, middle or last access cycle. The last case is the one where data would otherwise have been returned. Busy periods of one to four cycles cover both the shortest stall and longer holds, on single reads and on four-beat SEQ bursts. Both retry modes are used, which covers the interrupt and its clear.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_STALL  = 2'd2,
    ST_GAP    = 2'd3
  } fbrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;    // capture the address-phase address
    logic rdEn;        // bank read enable for this cycle
    logic dataValid;   // bank data is returned this cycle
    logic stallEvent;  // access abandoned because bank went busy
  } fbrStrobe_t;

  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [1:0] TRANS_SEQ    = 2'b11;
  localparam logic [2:0] MODE_RETRY_IRQ = 3'b110;

endpackage

// File: rtl/fbr_ctrl.sv
module fbr_ctrl
  import fbr_pkg::*;
#(
  parameter int READ_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hsel,
  input  logic [1:0] htrans,
  input  logic       hwrite,
  input  logic       hready,
  input  logic       bankDone,
  output logic       hreadyOut,
  output fbrStrobe_t strb
);

  localparam int CNT_W = (READ_CYCLES > 1) ? $clog2(READ_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(READ_CYCLES - 1);

  fbrState_e state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic accept, lastCycle, inAccess;

  assign accept    = hsel && hready && !hwrite &&
                     ((htrans == TRANS_NONSEQ) || (htrans == TRANS_SEQ));
  assign inAccess  = (state == ST_ACCESS);
  assign lastCycle = inAccess && (cnt == CNT_LAST);

  always_comb begin
    hreadyOut       = (state == ST_IDLE) || (lastCycle && bankDone);
    strb.rdEn       = inAccess;
    strb.dataValid  = lastCycle && bankDone;
    strb.stallEvent = inAccess && !bankDone;
    strb.loadAddr   = hreadyOut && accept;
  end

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          stateNext = ST_ACCESS;
          cntNext   = '0;
        end
      end
      ST_ACCESS: begin
        if (!bankDone) begin
          stateNext = ST_STALL;
          cntNext   = '0;
        end else if (cnt == CNT_LAST) begin
          cntNext   = '0;
          stateNext = accept ? ST_ACCESS : ST_IDLE;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_STALL: begin
        if (bankDone) stateNext = ST_GAP;
      end
      ST_GAP: begin
        stateNext = bankDone ? ST_ACCESS : ST_STALL;
        cntNext   = '0;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  AST_EN_DROPS_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && !bankDone) |=> !strb.rdEn); // R2
  AST_NO_READY_ON_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && !bankDone) |-> !hreadyOut); // R4
  AST_IDLE_GAP_BEFORE_RETRY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STALL && bankDone) |=> !strb.rdEn); // R3
  AST_NO_WRITE_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && hwrite) |=> !strb.rdEn); // R10

endmodule

// File: rtl/fbr_datapath.sv
module fbr_datapath
  import fbr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  fbrStrobe_t        strb,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [DATA_W-1:0] bankRdata,
  input  logic [2:0]        rwwMode,
  input  logic              stallIrqClr,
  output logic [ADDR_W-1:0] bankAddr,
  output logic              bankRdEn,
  output logic [DATA_W-1:0] hrdata,
  output logic              stallIrq
);

  logic [ADDR_W-1:0] addrReg;
  logic irqSet;

  assign irqSet   = strb.stallEvent && (rwwMode == MODE_RETRY_IRQ);
  assign bankAddr = addrReg;
  assign bankRdEn = strb.rdEn;
  assign hrdata   = strb.dataValid ? bankRdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrReg <= '0;
    else if (strb.loadAddr) addrReg <= haddr;
  end

  // sticky flag, a new stall wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stallIrq <= 1'b0;
    else if (irqSet) stallIrq <= 1'b1;
    else if (stallIrqClr) stallIrq <= 1'b0;
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadAddr |=> $stable(bankAddr)); // R3
  AST_IRQ_ONLY_MODE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stallIrq) |-> $past(rwwMode) == MODE_RETRY_IRQ); // R6
  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (stallIrqClr && !strb.stallEvent) |=> !stallIrq); // R7

endmodule

// File: rtl/flash_retry_reader.sv
module flash_retry_reader
  import fbr_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int READ_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsel,
  input  logic [1:0]        htrans,
  input  logic [ADDR_W-1:0] haddr,
  input  logic              hwrite,
  input  logic              hready,
  output logic              hreadyOut,
  output logic [DATA_W-1:0] hrdata,
  output logic              hresp,
  input  logic [2:0]        rwwMode,
  input  logic              stallIrqClr,
  output logic              stallIrq,
  output logic [ADDR_W-1:0] bankAddr,
  output logic              bankRdEn,
  input  logic [DATA_W-1:0] bankRdata,
  input  logic              bankDone
);

  fbrStrobe_t strb;

  assign hresp = 1'b0;

  fbr_ctrl #(.READ_CYCLES(READ_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .hsel(hsel), .htrans(htrans), .hwrite(hwrite),
    .hready(hready), .bankDone(bankDone), .hreadyOut(hreadyOut), .strb(strb)
  );

  fbr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .haddr(haddr), .bankRdata(bankRdata),
    .rwwMode(rwwMode), .stallIrqClr(stallIrqClr), .bankAddr(bankAddr),
    .bankRdEn(bankRdEn), .hrdata(hrdata), .stallIrq(stallIrq)
  );

endmodule

// File: tb/tb_flash_retry_reader.sv
module tb_flash_retry_reader;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int RC = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hsel = 1'b0;
  logic [1:0] htrans = 2'b00;
  logic [AW-1:0] haddr = '0;
  logic hwrite = 1'b0;
  logic hreadyOut, hresp, stallIrq, bankRdEn;
  logic [DW-1:0] hrdata, bankRdata;
  logic [AW-1:0] bankAddr;
  logic [2:0] rwwMode = 3'b110;
  logic stallIrqClr = 1'b0;
  logic bankDone = 1'b1;
  int total = 0;
  int bad = 0;
  logic irqExp = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] memData(input logic [AW-1:0] a);
    return {a, a ^ 16'hA5C3};
  endfunction

  assign bankRdata = memData(bankAddr);

  flash_retry_reader #(.ADDR_W(AW), .DATA_W(DW), .READ_CYCLES(RC)) dut (
    .clk(clk), .rstN(rstN), .hsel(hsel), .htrans(htrans), .haddr(haddr),
    .hwrite(hwrite), .hready(hreadyOut), .hreadyOut(hreadyOut), .hrdata(hrdata),
    .hresp(hresp), .rwwMode(rwwMode), .stallIrqClr(stallIrqClr),
    .stallIrq(stallIrq), .bankAddr(bankAddr), .bankRdEn(bankRdEn),
    .bankRdata(bankRdata), .bankDone(bankDone)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expLen(input int sCyc, input int sLen);
    return (sCyc == 0) ? RC : sCyc + sLen + 1 + RC;
  endfunction

  // burst of n beats from a0; beat sBeat sees bankDone low from data cycle sCyc for sLen cycles
  task automatic runBurst(input int n, input logic [AW-1:0] a0,
                          input int sBeat, input int sCyc, input int sLen);
    int beat = 0;
    int dBeat = -1;
    int cyc = 0;
    int lowLeft = 0;
    int want = RC;
    logic [AW-1:0] dAddr = '0;
    logic prevAddrOk = 1'b1;
    bit acceptNow, doneNow;
    while (1) begin
      hsel = 1'b1;
      hwrite = 1'b0;
      if (beat < n) begin
        htrans = (beat == 0) ? 2'b10 : 2'b11;
        haddr = a0 + AW'(4 * beat);
      end else htrans = 2'b00;
      if (dBeat >= 0) cyc++;
      if (dBeat == sBeat && sCyc != 0 && cyc == sCyc) lowLeft = sLen;
      bankDone = (lowLeft == 0);
      if (lowLeft > 0) lowLeft--;
      #1;
      if (dBeat == sBeat && sCyc != 0 && cyc == sCyc + 1)
        check(bankRdEn == 1'b0, "R2 rdEn low after busy", bankRdEn, 0);
      if (dBeat == sBeat && sCyc != 0 && cyc == sCyc)
        check(hreadyOut == 1'b0, "R2 no ready on busy cycle", hreadyOut, 0);
      if (dBeat >= 0 && hreadyOut) begin
        check(cyc == want, (dBeat == sBeat) ? "R3 retry latency" : "R1 latency", cyc, want);
        check(hrdata == memData(dAddr), (dBeat == sBeat) ? "R8 data after retry" : "R1 data",
              hrdata, memData(dAddr));
        check(bankRdEn && bankAddr == dAddr, "R3 bank address", bankAddr, dAddr);
        check(hresp == 1'b0, "R5 hresp okay", hresp, 0);
        if (dBeat > 0) check(prevAddrOk, "R8 next word", dAddr, a0 + AW'(4 * dBeat));
      end
      acceptNow = hreadyOut && (beat < n);
      doneNow = (dBeat >= 0) && hreadyOut;
      @(posedge clk);
      if (doneNow) dBeat = -1;
      if (acceptNow) begin
        dBeat = beat;
        dAddr = haddr;
        prevAddrOk = (haddr == a0 + AW'(4 * beat));
        cyc = 0;
        want = (beat == sBeat) ? expLen(sCyc, sLen) : RC;
        beat++;
      end
      @(negedge clk);
      if (beat >= n && dBeat < 0) break;
    end
    htrans = 2'b00;
    bankDone = 1'b1;
    if (sCyc != 0 && sBeat < n && rwwMode == 3'b110) irqExp = 1'b1;
    #1;
    check(stallIrq == irqExp, "R6 stall irq per mode", stallIrq, irqExp);
  endtask

  task automatic clearIrq();
    stallIrqClr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stallIrqClr = 1'b0;
    irqExp = 1'b0;
    #1;
    check(stallIrq == 1'b0, "R7 irq cleared", stallIrq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(hreadyOut == 1'b1, "R9 reset ready", hreadyOut, 1);
    check(bankRdEn == 1'b0, "R9 reset rdEn", bankRdEn, 0);
    check(stallIrq == 1'b0, "R9 reset irq", stallIrq, 0);
    @(negedge clk);

    // R10: write and idle transfers do not start a read
    hsel = 1'b1; hwrite = 1'b1; htrans = 2'b10; haddr = 16'h0040;
    @(negedge clk);
    hwrite = 1'b0; htrans = 2'b00;
    #1;
    check(bankRdEn == 1'b0 && hreadyOut, "R10 write ignored", bankRdEn, 0);
    @(negedge clk);
    #1;
    check(bankRdEn == 1'b0 && hreadyOut, "R10 idle ignored", bankRdEn, 0);
    @(negedge clk);

    // directed corners
    runBurst(1, 16'h0100, 0, 0, 0);        // R1 plain read
    rwwMode = 3'b111;
    runBurst(1, 16'h0200, 0, 1, 1);        // R3 busy in first cycle, silent mode
    runBurst(4, 16'h0300, 2, RC, 4);       // R8 busy in last cycle, mid burst
    rwwMode = 3'b110;
    runBurst(4, 16'h0400, 1, 2, 1);        // R6 irq mode
    runBurst(2, 16'h0500, 5, 0, 0);        // R7 irq held without stall
    clearIrq();
    runBurst(3, 16'h0600, 0, 1, 3);

    // random mix
    for (int i = 0; i < 60; i++) begin
      int n = 1 + int'($urandom_range(3));
      logic [AW-1:0] a = AW'({$urandom_range(16'h3FF0), 2'b00});
      int sb = ($urandom_range(1) == 1) ? int'($urandom_range(n - 1)) : 9;
      int sc = (sb == 9) ? 0 : 1 + int'($urandom_range(RC - 1));
      int sl = 1 + int'($urandom_range(3));
      rwwMode = ($urandom_range(1) == 1) ? 3'b110 : 3'b111;
      runBurst(n, a, sb, sc, sl);
      if ($urandom_range(3) == 0) clearIrq();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule